// File: doc/BRIEF.md
# Bus-Mapped Serial Port with Status Register

This block gives an 8-bit processor a fixed-rate asynchronous serial link through two I/O ports. Writing the data port hands one byte to the transmitter, which sends it as a frame of one low start bit, eight data bits (least significant first) and one high stop bit. Reading the same port returns the most recently received byte. The processor bus is assumed to be synchronous to the block clock.

The second port serves two roles. A read returns a four-bit status word that shows received data waiting, lost bytes, bad stop bits and a busy transmitter. A write sets a single enable bit for a non-maskable interrupt output. Bit timing is derived from the system clock by integer division to a 16x oversampling rate. The receiver takes each bit at its centre and discards start pulses that do not last until mid-bit.

A configuration parameter can turn off every read path. In that configuration writes, including transmit, still work.

Top module: `uart_io_port`

## Requirements
- R1: A write to port 0x0F makes `txd` send low start, data bits 0 to 7, then high stop. Each bit lasts exactly 16*floor(CLK_HZ/(BAUD*16)) clocks and starts on the clock after the write is seen. `txd` is high when idle.
- R2: A write to port 0x0F while a frame is still being sent is ignored, and the frame in progress continues unchanged.
- R3: Status bit 3 reads 1 from the write that starts a frame until the end of its stop bit, and reads 0 when the transmitter is idle.
- R4: A frame whose stop bit is sampled puts its byte in the receive register and sets status bit 0. Reading port 0x0F returns that byte and clears bit 0 when the read ends.
- R5: A byte that completes while status bit 0 is still 1 sets status bit 1 and replaces the older byte. A status read clears bits 1 and 2 when it ends but leaves bit 0 unchanged.
- R6: A stop bit sampled low sets status bit 2, and the byte is still delivered. The receiver then waits for the line to go high before it looks for the next start bit.
- R7: A low pulse on `rxd` that has ended by the middle of the start bit is discarded and delivers no byte.
- R8: A write to port 0x2F copies data bit 0 to `nmi_en`. No other write changes `nmi_en`.
- R9: A bus access is a cycle with `iorq_n` low and `rd_n` or `wr_n` low. A write acts once per access. `data_oe` is high only while ports 0x0F or 0x2F are being read, and status bits 7 to 4 read as 0.
- R10: With READ_EN = 0, `data_oe` never rises and reads have no side effects. Writes still start frames exactly as in R1.
- R11: After reset `txd` is high, `nmi_en` is 0 and the status word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Low byte of the I/O address |
| data_in | input | 8 | Write data from the processor |
| data_out | output | 8 | Read data to the processor |
| data_oe | output | 1 | High while `data_out` should drive the bus |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| nmi_en | output | 1 | Interrupt enable bit |

## Verification
A miscounted bit timer or shift position in the transmitter puts a wrong level on `txd` within one bit period. Comparing the line against a model on every clock catches it on the first cycle it differs. Errors in the receiver or in the flag logic stay hidden until the next read of a port. For that reason the bench reads status and data after every received frame, glitch and overrun case, and reads status again after each clear to show which flags persist. A latched enable that changes on an unrelated write shows up on `nmi_en` in the very next cycle.

// File: rtl/uart_io_pkg.sv
package uart_io_pkg;
    localparam int OVS = 16;
    localparam logic [7:0] PORT_DATA = 8'h0F;
    localparam logic [7:0] PORT_STAT = 8'h2F;

    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD} rx_st_e;

    typedef struct packed {
        logic       busy;
        logic [9:0] frame;
        logic [3:0] bitn;
        logic [3:0] sub;
    } tx_state_t;

    typedef struct packed {
        rx_st_e     st;
        logic [1:0] sync;
        logic [3:0] sub;
        logic [2:0] bitn;
        logic [7:0] shreg;
        logic       done;
        logic       bad;
    } rx_state_t;

    typedef struct packed {
        logic       wr_act;
        logic       rd_act;
        logic       rd_data;
        logic       rd_stat;
        logic [7:0] rx_byte;
        logic       avail;
        logic       ovr;
        logic       ferr;
        logic       nmi;
    } bus_state_t;
endpackage

// File: rtl/uart_io_tick.sv
module uart_io_tick #(
    parameter int DIV = 27
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        tick  = !clr && (cnt_q == CW'(DIV - 1));
        cnt_d = (clr || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uart_io_tx.sv
module uart_io_tx import uart_io_pkg::*; #(
    parameter int DIV = 27
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] data,
    output logic       txd,
    output logic       busy
);
    tx_state_t s_q, s_d;
    logic      tick, load, bit_end;

    assign load    = start && !s_q.busy;
    assign bit_end = s_q.busy && tick && (s_q.sub == 4'(OVS - 1));

    uart_io_tick #(.DIV(DIV)) i_tick (.clk(clk), .rst_n(rst_n), .clr(load), .tick(tick));

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.busy  = 1'b1;
            s_d.frame = {1'b1, data, 1'b0};
            s_d.bitn  = '0;
            s_d.sub   = '0;
        end else if (s_q.busy && tick) begin
            if (bit_end) begin
                s_d.sub = '0;
                if (s_q.bitn == 4'd9) begin
                    s_d.busy = 1'b0;
                end else begin
                    s_d.bitn  = s_q.bitn + 1'b1;
                    s_d.frame = {1'b1, s_q.frame[9:1]};
                end
            end else begin
                s_d.sub = s_q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{busy: 1'b0, frame: '1, bitn: '0, sub: '0};
        else        s_q <= s_d;
    end

    assign txd  = s_q.busy ? s_q.frame[0] : 1'b1;
    assign busy = s_q.busy;

    // R1: the line only moves at bit boundaries during a frame
    a_r1_txd_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !bit_end) |=> $stable(txd));
    // R1: a frame always ends on a high stop level
    a_r1_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.busy) |-> $past(txd));
endmodule

// File: rtl/uart_io_rx.sv
module uart_io_rx import uart_io_pkg::*; #(
    parameter int DIV = 27
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    output logic       done,
    output logic       bad,
    output logic [7:0] data
);
    rx_state_t s_q, s_d;
    logic      tick, rxs, hunting;

    assign rxs     = s_q.sync[1];
    assign hunting = (s_q.st == RX_IDLE) || (s_q.st == RX_HOLD);

    uart_io_tick #(.DIV(DIV)) i_tick (.clk(clk), .rst_n(rst_n), .clr(hunting), .tick(tick));

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[0], rxd};
        s_d.done = 1'b0;
        s_d.bad  = 1'b0;
        unique case (s_q.st)
            RX_IDLE: if (!rxs) begin
                s_d.st  = RX_START;
                s_d.sub = '0;
            end
            RX_START: if (tick) begin
                if (s_q.sub == 4'(OVS / 2 - 1)) begin
                    s_d.sub  = '0;
                    s_d.bitn = '0;
                    s_d.st   = rxs ? RX_IDLE : RX_DATA;
                end else begin
                    s_d.sub = s_q.sub + 1'b1;
                end
            end
            RX_DATA: if (tick) begin
                if (s_q.sub == 4'(OVS - 1)) begin
                    s_d.sub   = '0;
                    s_d.shreg = {rxs, s_q.shreg[7:1]};
                    if (s_q.bitn == 3'd7) s_d.st = RX_STOP;
                    else                  s_d.bitn = s_q.bitn + 1'b1;
                end else begin
                    s_d.sub = s_q.sub + 1'b1;
                end
            end
            RX_STOP: if (tick) begin
                if (s_q.sub == 4'(OVS - 1)) begin
                    s_d.sub  = '0;
                    s_d.done = 1'b1;
                    s_d.bad  = !rxs;
                    s_d.st   = rxs ? RX_IDLE : RX_HOLD;
                end else begin
                    s_d.sub = s_q.sub + 1'b1;
                end
            end
            RX_HOLD: if (rxs) s_d.st = RX_IDLE;
            default: s_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: RX_IDLE, sync: 2'b11, sub: '0, bitn: '0,
                             shreg: '0, done: 1'b0, bad: 1'b0};
        else        s_q <= s_d;
    end

    assign done = s_q.done;
    assign bad  = s_q.bad;
    assign data = s_q.shreg;

    // R7: a start pulse gone by mid-bit sends the receiver back to hunting
    a_r7_glitch_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == RX_START && tick && s_q.sub == 4'(OVS / 2 - 1) && rxs) |=> (s_q.st == RX_IDLE));
endmodule

// File: rtl/uart_io_port.sv
module uart_io_port import uart_io_pkg::*; #(
    parameter int CLK_HZ  = 50_000_000,
    parameter int BAUD    = 115_200,
    parameter bit READ_EN = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] addr,
    input  logic [7:0] data_in,
    output logic [7:0] data_out,
    output logic       data_oe,
    input  logic       iorq_n,
    input  logic       rd_n,
    input  logic       wr_n,
    output logic       txd,
    input  logic       rxd,
    output logic       nmi_en
);
    localparam int DIV = CLK_HZ / (BAUD * OVS);

    bus_state_t s_q, s_d;
    logic       wr_now, rd_now, wr_pulse, rd_end, tx_start, tx_busy;
    logic       rx_done, rx_bad;
    logic [7:0] rx_data;

    assign wr_now   = !iorq_n && !wr_n;
    assign rd_now   = READ_EN && !iorq_n && !rd_n;
    assign wr_pulse = wr_now && !s_q.wr_act;
    assign rd_end   = s_q.rd_act && !rd_now;
    assign tx_start = wr_pulse && (addr == PORT_DATA);

    uart_io_tx #(.DIV(DIV)) i_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .data(data_in),
        .txd(txd), .busy(tx_busy));

    uart_io_rx #(.DIV(DIV)) i_rx (
        .clk(clk), .rst_n(rst_n), .rxd(rxd),
        .done(rx_done), .bad(rx_bad), .data(rx_data));

    always_comb begin
        s_d         = s_q;
        s_d.wr_act  = wr_now;
        s_d.rd_act  = rd_now;
        s_d.rd_data = rd_now && (addr == PORT_DATA);
        s_d.rd_stat = rd_now && (addr == PORT_STAT);
        if (wr_pulse && addr == PORT_STAT) s_d.nmi = data_in[0];
        if (rd_end && s_q.rd_data) s_d.avail = 1'b0;
        if (rd_end && s_q.rd_stat) begin
            s_d.ovr  = 1'b0;
            s_d.ferr = 1'b0;
        end
        if (rx_done) begin
            s_d.ovr     = s_d.ovr | s_d.avail;
            s_d.avail   = 1'b1;
            s_d.rx_byte = rx_data;
            if (rx_bad) s_d.ferr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{wr_act: 1'b0, rd_act: 1'b0, rd_data: 1'b0, rd_stat: 1'b0,
                             rx_byte: '0, avail: 1'b0, ovr: 1'b0, ferr: 1'b0, nmi: 1'b0};
        else        s_q <= s_d;
    end

    assign data_oe  = rd_now && (addr == PORT_DATA || addr == PORT_STAT);
    assign data_out = (addr == PORT_DATA) ? s_q.rx_byte
                                          : {4'b0000, tx_busy, s_q.ferr, s_q.ovr, s_q.avail};
    assign nmi_en   = s_q.nmi;

    // R9: the bus is driven only inside a read access
    a_r9_oe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (!iorq_n && !rd_n));
    // R5: a byte landing on unread data flags an overrun
    a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && s_q.avail && !(rd_end && s_q.rd_data)) |=> (s_q.ovr && s_q.avail));
    // R8: the enable bit moves only on a write to the status port
    a_r8_nmi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_pulse && addr == PORT_STAT) |=> $stable(nmi_en));
endmodule

// File: tb/test_uart_io_port.sv
module test_uart_io_port;
    localparam int DIV  = 50_000_000 / (115_200 * 16);
    localparam int BITC = DIV * 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = 8'h00, data_in = 8'h00;
    logic       iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, rxd = 1'b1;
    logic [7:0] data_out, data_out2;
    logic       data_oe, data_oe2, txd, txd2, nmi_en, nmi_en2;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    uart_io_port i_uart_io_port (
        .clk(clk), .rst_n(rst_n), .addr(addr), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .iorq_n(iorq_n), .rd_n(rd_n),
        .wr_n(wr_n), .txd(txd), .rxd(rxd), .nmi_en(nmi_en));

    uart_io_port #(.READ_EN(1'b0)) i_noread (
        .clk(clk), .rst_n(rst_n), .addr(addr), .data_in(data_in),
        .data_out(data_out2), .data_oe(data_oe2), .iorq_n(iorq_n), .rd_n(rd_n),
        .wr_n(wr_n), .txd(txd2), .rxd(rxd), .nmi_en(nmi_en2));

    task automatic chk(input string req, input int act, input int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp_v, $time);
        end
    endtask

    // behavioural reference: transmitter line and enable bit
    bit        m_busy = 0, m_nmi = 0, m_wr_prev = 0;
    bit [9:0]  m_frame = '1;
    int        m_bit = 0, m_cnt = 0;
    logic      exp_txd;
    assign exp_txd = m_busy ? m_frame[m_bit] : 1'b1;

    always @(posedge clk) begin
        bit wr_now;
        wr_now = !iorq_n && !wr_n;
        if (!rst_n) begin
            m_busy <= 0; m_nmi <= 0; m_wr_prev <= 0;
        end else begin
            m_wr_prev <= wr_now;
            if (wr_now && !m_wr_prev && addr == 8'h2F) m_nmi <= data_in[0];
            if (m_busy) begin
                if (m_cnt == BITC - 1) begin
                    m_cnt <= 0;
                    if (m_bit == 9) m_busy <= 0;
                    else            m_bit  <= m_bit + 1;
                end else m_cnt <= m_cnt + 1;
            end else if (wr_now && !m_wr_prev && addr == 8'h0F) begin
                m_busy <= 1; m_frame <= {1'b1, data_in, 1'b0}; m_bit <= 0; m_cnt <= 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R1/R2 txd", txd, exp_txd);
            chk("R10 txd no-read variant", txd2, exp_txd);
            chk("R10 data_oe no-read variant", data_oe2, 0);
            chk("R8 nmi_en", nmi_en, m_nmi);
        end
    end

    // expected receive-side flags
    bit       e_avail = 0, e_ovr = 0, e_ferr = 0;
    bit [7:0] e_data = 0;

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; data_in = d; iorq_n = 0; wr_n = 0;
        @(negedge clk); @(negedge clk);
        iorq_n = 1; wr_n = 1;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk); addr = a; iorq_n = 0; rd_n = 0;
        @(negedge clk); d = data_out; oe = data_oe;
        iorq_n = 1; rd_n = 1;
        @(negedge clk);
    endtask

    task automatic read_status(input string req);
        logic [7:0] v; logic oe;
        bit [7:0] e;
        e = {4'b0000, m_busy, e_ferr, e_ovr, e_avail};
        bus_read(8'h2F, v, oe);
        chk(req, v, e);
        chk({req, " oe"}, oe, 1);
        e_ovr = 0; e_ferr = 0;
    endtask

    task automatic read_data(input string req);
        logic [7:0] v; logic oe;
        bus_read(8'h0F, v, oe);
        chk(req, v, e_data);
        chk({req, " oe"}, oe, 1);
        e_avail = 0;
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop_lvl);
        @(negedge clk); rxd = 0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BITC) @(negedge clk);
        end
        rxd = stop_lvl;
        repeat (BITC) @(negedge clk);
        rxd = 1;
        repeat (BITC / 2) @(negedge clk);
        e_ovr   = e_ovr | e_avail;
        e_avail = 1;
        e_data  = b;
        if (!stop_lvl) e_ferr = 1;
    endtask

    initial begin
        logic [7:0] v; logic oe;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        chk("R11 txd idle", txd, 1);
        chk("R11 nmi_en", nmi_en, 0);
        read_status("R11 status after reset");

        // R8: enable bit set, cleared, untouched by other writes
        bus_write(8'h2F, 8'h01);
        chk("R8 nmi set", nmi_en, 1);
        bus_write(8'h2F, 8'hFE);
        chk("R8 nmi cleared by D0=0", nmi_en, 0);
        bus_write(8'h2F, 8'h01);
        bus_write(8'h1F, 8'h00);
        chk("R8 nmi kept on other port", nmi_en, 1);

        // R9: unmapped read does not drive the bus
        bus_read(8'h1F, v, oe);
        chk("R9 no oe on unmapped port", oe, 0);

        // R1/R3: frame send, status busy then idle; R2: write while busy
        bus_write(8'h0F, 8'hA5);
        read_status("R3 transmitter full");
        bus_write(8'h0F, 8'h3C);
        wait (!m_busy);
        repeat (3) @(negedge clk);
        read_status("R3 transmitter idle");
        bus_write(8'h0F, 8'h81);

        // R4: simple receive
        send_rx(8'h5A, 1);
        read_status("R4 data waiting");
        read_data("R4 received byte");
        read_status("R4 flag cleared by data read");

        // R5: overrun
        send_rx(8'h11, 1);
        send_rx(8'h22, 1);
        read_status("R5 overrun flagged");
        read_status("R5 status read clears only overrun");
        read_data("R5 newest byte kept");
        read_status("R5 all clear");

        // R6: framing error and recovery
        send_rx(8'h33, 0);
        read_status("R6 framing error");
        read_data("R6 byte still delivered");
        send_rx(8'hC4, 1);
        read_status("R6 receiver recovered");
        read_data("R6 next byte");

        // R7: short start pulse rejected
        @(negedge clk); rxd = 0;
        repeat (BITC / 4) @(negedge clk);
        rxd = 1;
        repeat (2 * BITC) @(negedge clk);
        read_status("R7 glitch gave no byte");
        send_rx(8'h66, 1);
        read_data("R7 receiver still works");

        wait (!m_busy);
        repeat (4) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200_000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule